// File: doc/BRIEF.md
# Hybrid Multi-Page-Size Translation Buffer

This block caches virtual-to-physical address translations for four page sizes: 8 KB, 64 KB, 512 KB and 4 MB. It keeps three structures and searches all of them at once on every lookup. A 2-way set-associative array holds unlocked 8 KB pages. A second 2-way set-associative array holds 4 MB pages. A small fully associative array holds the intermediate sizes and every locked translation, whatever its size.

Where an unlocked 4 MB page goes depends on a mode input. It is stored either in the large-page array or in the fully associative array, and never in both. One copy of the block serves instruction fetch and another serves data access.

A lookup presents a 64-bit virtual address and a context. Exactly one cycle later the block returns a hit flag, the physical address, the page attributes and the page size. The fill port writes one translation per cycle. The invalidate-all strobe drops every unlocked translation in one cycle.

Top module: `hybrid_tlb`

## Requirements
- R1: A lookup request in one cycle raises the response strobe in the next cycle and only then. Response and hit are low after reset.
- R2: An unlocked fill with size code 00 (8 KB) is found by later lookups anywhere in that page. The result has size 00, the stored attributes, and a physical address made of the stored frame above bit 13 and the virtual address bits 12..0.
- R3: Size codes 01 (64 KB, offset bits 15..0) and 10 (512 KB, offset bits 18..0) go to the fully associative array. A lookup at any offset in the page hits, and the physical address takes its offset bits from the virtual address.
- R4: With mode_4m_fa low, an unlocked size-11 fill goes to the 4 MB set-associative array. With mode_4m_fa high, it goes to the fully associative array. Locked fills of any size always go to the fully associative array.
- R5: A lookup whose context differs from the context stored with the translation misses.
- R6: In a set-associative array, a fill takes an invalid way of its set first. Once both ways are valid, a per-set round-robin bit picks the victim, so the third and fourth fills to one set evict the first and second fills in that order.
- R7: In the fully associative array, a fill takes the lowest invalid entry first. Otherwise it takes the next unlocked entry at or after a round-robin pointer, and the pointer then moves past that entry, so locked entries are never evicted.
- R8: When several structures hit at once, the fully associative result is returned and lk_multi is raised. Otherwise lk_multi stays low.
- R9: A one-cycle inv_all pulse removes every unlocked translation and leaves locked translations in place.
- R10: A hit on a 4 MB page has size 11 and takes physical address bits 21..0 from the virtual address.
- R11: A fill bound for the fully associative array while all of its entries are locked is dropped. fill_ovf is high in the cycle after that fill and low after any other fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_4m_fa | input | 1 | 1: unlocked 4 MB fills go to the fully associative array |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_ctx | input | CTX_W | Lookup context |
| lk_rsp | output | 1 | Lookup result valid, one cycle after lk_req |
| lk_hit | output | 1 | Translation found |
| lk_pa | output | PA_W | Physical address (zero on miss) |
| lk_attr | output | ATTR_W | Attributes of the hit translation |
| lk_size | output | 2 | Page size code of the hit translation |
| lk_multi | output | 1 | More than one structure hit |
| fill_en | input | 1 | Fill strobe |
| fill_vpn | input | VA_W-13 | Virtual address bits above 13 |
| fill_ctx | input | CTX_W | Fill context |
| fill_ppn | input | PA_W-13 | Physical address bits above 13 |
| fill_size | input | 2 | Size code: 00 8 KB, 01 64 KB, 10 512 KB, 11 4 MB |
| fill_lock | input | 1 | Locked translation |
| fill_attr | input | ATTR_W | Page attributes |
| fill_ovf | output | 1 | Fill dropped because every fully associative entry is locked |
| inv_all | input | 1 | Invalidate all unlocked translations |

## Verification
The bench builds the block with 16 entries per set-associative array (8 sets) and 8 fully associative entries. It keeps the 64-bit virtual and 44-bit physical widths.

With these sizes, a set conflict takes only pages 64 KB apart. Filling the whole fully associative array with locked entries takes eight fills. The round-robin eviction order in both kinds of array and the overflow drop are therefore reached with short directed sequences. Random pages spread over every set of the small arrays then exercise mixed sizes and offsets.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned BASE_SH = 13;
  localparam int unsigned BIG_SH  = 22;

  typedef enum logic [1:0] {
    PG_8K   = 2'b00,
    PG_64K  = 2'b01,
    PG_512K = 2'b10,
    PG_4M   = 2'b11
  } pg_size_e;

  // number of offset bits for a size code
  function automatic int unsigned pg_shift(input logic [1:0] sz);
    case (sz)
      2'b00:   pg_shift = 13;
      2'b01:   pg_shift = 16;
      2'b10:   pg_shift = 19;
      default: pg_shift = 22;
    endcase
  endfunction
endpackage

// File: rtl/tlb_sa_bank.sv
// One 2-way set-associative translation array for a single page size.
// Data ways sit in inferable RAM with a registered read; valid and
// round-robin bits are flops so that invalidate-all takes one cycle.
module tlb_sa_bank #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 44,
  parameter int CTX_W  = 13,
  parameter int ATTR_W = 8,
  parameter int SETS   = 512,
  parameter int PG_SH  = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_req,
  input  logic [VA_W-PG_SH-1:0] lk_vpn,
  input  logic [CTX_W-1:0]      lk_ctx,
  input  logic                  fill_we,
  input  logic [VA_W-PG_SH-1:0] fill_vpn,
  input  logic [CTX_W-1:0]      fill_ctx,
  input  logic [PA_W-PG_SH-1:0] fill_frame,
  input  logic [ATTR_W-1:0]     fill_attr,
  input  logic                  inv_all,
  output logic                  hit,
  output logic [PA_W-PG_SH-1:0] frame,
  output logic [ATTR_W-1:0]     attr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VA_W - PG_SH - IDX_W;
  localparam int FR_W  = PA_W - PG_SH;
  localparam int DW    = TAG_W + CTX_W + FR_W + ATTR_W;

  logic [IDX_W-1:0] lk_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, tag_q;
  logic [CTX_W-1:0] ctx_q;
  logic [DW-1:0]    f_word;
  logic [1:0]       vld [SETS];
  logic [SETS-1:0]  rr;
  logic [1:0]       vld_q;
  logic             vic;
  logic [1:0]       hit_w;
  logic [FR_W-1:0]  fr_w [2];
  logic [ATTR_W-1:0] at_w [2];

  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VA_W-PG_SH-1:IDX_W];
  assign f_idx  = fill_vpn[IDX_W-1:0];
  assign f_word = {fill_vpn[VA_W-PG_SH-1:IDX_W], fill_ctx, fill_frame, fill_attr};

  // victim: invalid way first, then the set's round-robin bit
  always_comb begin
    if (!vld[f_idx][0])      vic = 1'b0;
    else if (!vld[f_idx][1]) vic = 1'b1;
    else                     vic = rr[f_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld[s] <= 2'b00;
      rr <= '0;
    end else begin
      if (inv_all)
        for (int s = 0; s < SETS; s++) vld[s] <= 2'b00;
      if (fill_we) begin
        vld[f_idx][vic] <= 1'b1;
        rr[f_idx]       <= ~vic;
      end
    end
  end

  // capture of the request side for the compare stage
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 2'b00;
      tag_q <= '0;
      ctx_q <= '0;
    end else if (lk_req) begin
      vld_q <= vld[lk_idx];
      tag_q <= lk_tag;
      ctx_q <= lk_ctx;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DW-1:0] mem [SETS];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (fill_we && (vic == w[0])) mem[f_idx] <= f_word;
    end

    always_ff @(posedge clk) begin
      if (lk_req) rd_q <= mem[lk_idx];
    end

    assign hit_w[w] = vld_q[w] && (rd_q[DW-1 -: TAG_W] == tag_q) &&
                      (rd_q[DW-TAG_W-1 -: CTX_W] == ctx_q);
    assign fr_w[w]  = rd_q[ATTR_W +: FR_W];
    assign at_w[w]  = rd_q[ATTR_W-1:0];
  end

  assign hit   = |hit_w;
  assign frame = hit_w[0] ? fr_w[0] : fr_w[1];
  assign attr  = hit_w[0] ? at_w[0] : at_w[1];
endmodule

// File: rtl/tlb_fa_bank.sv
// Fully associative array for mixed page sizes and locked translations.
module tlb_fa_bank
  import tlb_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 44,
  parameter int CTX_W  = 13,
  parameter int ATTR_W = 8,
  parameter int N      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_req,
  input  logic [VA_W-14:0]   lk_vpn,
  input  logic [CTX_W-1:0]   lk_ctx,
  input  logic               fill_we,
  input  logic [VA_W-14:0]   fill_vpn,
  input  logic [CTX_W-1:0]   fill_ctx,
  input  logic [PA_W-14:0]   fill_frame,
  input  logic [ATTR_W-1:0]  fill_attr,
  input  logic [1:0]         fill_size,
  input  logic               fill_lock,
  input  logic               inv_all,
  output logic               hit,
  output logic [PA_W-14:0]   frame,
  output logic [ATTR_W-1:0]  attr,
  output logic [1:0]         size,
  output logic               ovf
);
  localparam int IW = $clog2(N);
  localparam int TW = VA_W - 13;
  localparam int FW = PA_W - 13;

  logic [N-1:0]      vld, lck, match;
  logic [TW-1:0]     tag [N];
  logic [CTX_W-1:0]  ctx [N];
  logic [FW-1:0]     fr  [N];
  logic [ATTR_W-1:0] at  [N];
  logic [1:0]        sz  [N];
  logic [IW-1:0]     rr, vic, sel, j;
  logic              found, via_rr;

  // parallel compare, offset bits masked per entry size
  always_comb begin
    for (int i = 0; i < N; i++) begin
      match[i] = vld[i] && (ctx[i] == lk_ctx) &&
                 (((tag[i] ^ lk_vpn) & ({TW{1'b1}} << (pg_shift(sz[i]) - BASE_SH))) == '0);
    end
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) sel = IW'(i);
  end

  // victim: lowest invalid entry, else next unlocked from the pointer
  always_comb begin
    found  = 1'b0;
    via_rr = 1'b0;
    vic    = '0;
    j      = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !vld[i]) begin
        vic   = IW'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      j = rr + IW'(i);
      if (!found && !lck[j]) begin
        vic    = j;
        found  = 1'b1;
        via_rr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      lck <= '0;
      rr  <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= fill_we && !found;
      if (inv_all) vld <= vld & lck;
      if (fill_we && found) begin
        vld[vic] <= 1'b1;
        lck[vic] <= fill_lock;
        if (via_rr) rr <= vic + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we && found) begin
      tag[vic] <= fill_vpn;
      ctx[vic] <= fill_ctx;
      fr[vic]  <= fill_frame;
      at[vic]  <= fill_attr;
      sz[vic]  <= fill_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit   <= 1'b0;
      frame <= '0;
      attr  <= '0;
      size  <= 2'b00;
    end else if (lk_req) begin
      hit   <= |match;
      frame <= fr[sel];
      attr  <= at[sel];
      size  <= sz[sel];
    end
  end
endmodule

// File: rtl/hybrid_tlb.sv
module hybrid_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int CTX_W      = 13,
  parameter int ATTR_W     = 8,
  parameter int SA_ENTRIES = 1024,
  parameter int FA_ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_4m_fa,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [CTX_W-1:0]  lk_ctx,
  output logic              lk_rsp,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [1:0]        lk_size,
  output logic              lk_multi,
  input  logic              fill_en,
  input  logic [VA_W-14:0]  fill_vpn,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [PA_W-14:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic              fill_lock,
  input  logic [ATTR_W-1:0] fill_attr,
  output logic              fill_ovf,
  input  logic              inv_all
);
  localparam int SETS  = SA_ENTRIES / 2;
  localparam int GAP   = BIG_SH - BASE_SH;
  localparam int FR4_W = PA_W - BIG_SH;

  logic              to_s8, to_s4, to_fa;
  logic              rsp_q;
  logic [BIG_SH-1:0] off_q;

  logic              s8_hit, s4_hit, fa_hit;
  logic [PA_W-14:0]  s8_fr, fa_fr;
  logic [FR4_W-1:0]  s4_fr;
  logic [ATTR_W-1:0] s8_at, s4_at, fa_at;
  logic [1:0]        fa_sz;

  logic              h8, h4, hf, any_hit;
  logic [PA_W-14:0]  sel_fr;
  logic [ATTR_W-1:0] sel_at;
  logic [1:0]        sel_sz;
  logic [PA_W-1:0]   omask, pa_base, off_ext;

  // fill steering: each translation lands in exactly one structure
  always_comb begin
    to_s8 = fill_en && !fill_lock && (fill_size == PG_8K);
    to_s4 = fill_en && !fill_lock && (fill_size == PG_4M) && !mode_4m_fa;
    to_fa = fill_en && !to_s8 && !to_s4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= 1'b0;
      off_q <= '0;
    end else begin
      rsp_q <= lk_req;
      if (lk_req) off_q <= lk_va[BIG_SH-1:0];
    end
  end

  tlb_sa_bank #(
    .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .ATTR_W(ATTR_W),
    .SETS(SETS), .PG_SH(BASE_SH)
  ) u_sa8 (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_vpn(lk_va[VA_W-1:BASE_SH]), .lk_ctx(lk_ctx),
    .fill_we(to_s8), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx),
    .fill_frame(fill_ppn), .fill_attr(fill_attr), .inv_all(inv_all),
    .hit(s8_hit), .frame(s8_fr), .attr(s8_at)
  );

  tlb_sa_bank #(
    .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .ATTR_W(ATTR_W),
    .SETS(SETS), .PG_SH(BIG_SH)
  ) u_sa4m (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_vpn(lk_va[VA_W-1:BIG_SH]), .lk_ctx(lk_ctx),
    .fill_we(to_s4), .fill_vpn(fill_vpn[VA_W-14:GAP]), .fill_ctx(fill_ctx),
    .fill_frame(fill_ppn[PA_W-14:GAP]), .fill_attr(fill_attr), .inv_all(inv_all),
    .hit(s4_hit), .frame(s4_fr), .attr(s4_at)
  );

  tlb_fa_bank #(
    .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .ATTR_W(ATTR_W), .N(FA_ENTRIES)
  ) u_fa (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_vpn(lk_va[VA_W-1:BASE_SH]), .lk_ctx(lk_ctx),
    .fill_we(to_fa), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx),
    .fill_frame(fill_ppn), .fill_attr(fill_attr), .fill_size(fill_size),
    .fill_lock(fill_lock), .inv_all(inv_all),
    .hit(fa_hit), .frame(fa_fr), .attr(fa_at), .size(fa_sz), .ovf(fill_ovf)
  );

  // result merge: fully associative first, then large page, then 8 KB
  always_comb begin
    h8      = rsp_q && s8_hit;
    h4      = rsp_q && s4_hit;
    hf      = rsp_q && fa_hit;
    any_hit = h8 || h4 || hf;
    if (hf) begin
      sel_fr = fa_fr;
      sel_at = fa_at;
      sel_sz = fa_sz;
    end else if (h4) begin
      sel_fr = {s4_fr, {GAP{1'b0}}};
      sel_at = s4_at;
      sel_sz = PG_4M;
    end else begin
      sel_fr = s8_fr;
      sel_at = s8_at;
      sel_sz = PG_8K;
    end
    omask   = ~({PA_W{1'b1}} << pg_shift(sel_sz));
    pa_base = {sel_fr, {BASE_SH{1'b0}}};
    off_ext = {{(PA_W-BIG_SH){1'b0}}, off_q};
  end

  assign lk_rsp   = rsp_q;
  assign lk_hit   = any_hit;
  assign lk_pa    = any_hit ? ((pa_base & ~omask) | (off_ext & omask)) : '0;
  assign lk_attr  = any_hit ? sel_at : '0;
  assign lk_size  = any_hit ? sel_sz : 2'b00;
  assign lk_multi = (hf && h4) || (hf && h8) || (h4 && h8);
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int VA_W = 64,
  parameter int PA_W = 44
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_va,
  input logic            lk_rsp,
  input logic            lk_hit,
  input logic [PA_W-1:0] lk_pa,
  input logic [1:0]      lk_size,
  input logic            lk_multi,
  input logic            fill_en,
  input logic            fill_ovf
);
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_rsp);

  p_rsp_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
    lk_rsp |-> $past(lk_req));

  p_hit_in_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_rsp);

  p_offset_8k_r2: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_size == 2'b00) |-> (lk_pa[12:0] == $past(lk_va[12:0])));

  p_offset_4m_r10: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_size == 2'b11) |-> (lk_pa[21:0] == $past(lk_va[21:0])));

  p_multi_is_hit_r8: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit);

  p_ovf_after_fill_r11: assert property (@(posedge clk) disable iff (rst)
    fill_ovf |-> $past(fill_en));
endmodule

bind hybrid_tlb tlb_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va), .lk_rsp(lk_rsp),
  .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_size(lk_size), .lk_multi(lk_multi),
  .fill_en(fill_en), .fill_ovf(fill_ovf)
);

// File: tb/hybrid_tlb_tb.sv
module hybrid_tlb_tb;
  localparam int VA_W = 64, PA_W = 44, CTX_W = 8, ATTR_W = 8;
  localparam int SA_N = 16, FA_N = 8;

  logic clk = 0, rst = 1, mode_4m_fa = 0;
  logic lk_req = 0;
  logic [VA_W-1:0] lk_va = '0;
  logic [CTX_W-1:0] lk_ctx = '0;
  logic lk_rsp, lk_hit, lk_multi, fill_ovf;
  logic [PA_W-1:0] lk_pa;
  logic [ATTR_W-1:0] lk_attr;
  logic [1:0] lk_size;
  logic fill_en = 0, fill_lock = 0, inv_all = 0;
  logic [VA_W-14:0] fill_vpn = '0;
  logic [CTX_W-1:0] fill_ctx = '0;
  logic [PA_W-14:0] fill_ppn = '0;
  logic [1:0] fill_size = 0;
  logic [ATTR_W-1:0] fill_attr = '0;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hybrid_tlb #(.VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .ATTR_W(ATTR_W),
               .SA_ENTRIES(SA_N), .FA_ENTRIES(FA_N)) u_dut (
    .clk(clk), .rst(rst), .mode_4m_fa(mode_4m_fa),
    .lk_req(lk_req), .lk_va(lk_va), .lk_ctx(lk_ctx), .lk_rsp(lk_rsp),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_size(lk_size),
    .lk_multi(lk_multi), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ctx(fill_ctx), .fill_ppn(fill_ppn), .fill_size(fill_size),
    .fill_lock(fill_lock), .fill_attr(fill_attr), .fill_ovf(fill_ovf),
    .inv_all(inv_all));

  function automatic int shift_of(input logic [1:0] s);
    return (s == 2'b00) ? 13 : (s == 2'b01) ? 16 : (s == 2'b10) ? 19 : 22;
  endfunction

  function automatic logic [PA_W-1:0] exp_pa(input logic [PA_W-1:0] pa,
      input logic [1:0] s, input logic [VA_W-1:0] va);
    logic [PA_W-1:0] m;
    m = ~({PA_W{1'b1}} << shift_of(s));
    return (pa & ~m) | (va[PA_W-1:0] & m);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; mode_4m_fa = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic fill(input logic [63:0] va, input logic [CTX_W-1:0] c,
      input logic [PA_W-1:0] pa, input logic [1:0] s, input logic lk,
      input logic [ATTR_W-1:0] a);
    @(negedge clk);
    fill_en = 1; fill_vpn = va[VA_W-1:13]; fill_ctx = c; fill_ppn = pa[PA_W-1:13];
    fill_size = s; fill_lock = lk; fill_attr = a;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input logic [63:0] va, input logic [CTX_W-1:0] c);
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_ctx = c;
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [63:0] rv_va [14];
  logic [PA_W-1:0] rv_pa [14];
  logic [1:0] rv_sz [14];

  initial begin
    logic [63:0] va, m;
    void'($urandom(32'd2024));
    do_reset();
    // R11 / R1: reset state
    check("R1 rsp idle after reset", lk_rsp, 0);
    look(64'h1234_0000_0000_2000, 8'd1);
    check("R1 rsp after request", lk_rsp, 1);
    check("R1 miss after reset", lk_hit, 0);
    @(negedge clk);
    check("R1 rsp drops without request", lk_rsp, 0);

    // R2: 8 KB page
    fill(64'h0000_00AB_CDEF_6000, 8'd5, 44'hABC_DEF1_2000, 2'b00, 0, 8'h5A);
    check("R11 no ovf on normal fill", fill_ovf, 0);
    look(64'h0000_00AB_CDEF_7ABC, 8'd5);
    check("R2 hit 8K", lk_hit, 1);
    check("R2 pa 8K", lk_pa, 44'hABC_DEF1_3ABC);
    check("R2 size", lk_size, 0);
    check("R2 attr", lk_attr, 8'h5A);
    check("R8 no multi single hit", lk_multi, 0);
    // R5: context mismatch
    look(64'h0000_00AB_CDEF_7ABC, 8'd6);
    check("R5 ctx mismatch miss", lk_hit, 0);

    // R3: 64 KB and 512 KB pages
    fill(64'h0000_0100_0003_0000, 8'd5, 44'h123_4560_0000, 2'b01, 0, 8'h11);
    fill(64'h0000_0200_0008_0000, 8'd5, 44'h777_0000_0000, 2'b10, 0, 8'h22);
    look(64'h0000_0100_0003_F123, 8'd5);
    check("R3 hit 64K", lk_hit, 1);
    check("R3 pa 64K", lk_pa, 44'h123_4560_F123);
    check("R3 size 64K", lk_size, 2'b01);
    look(64'h0000_0200_000F_FFFF, 8'd5);
    check("R3 pa 512K", lk_pa, 44'h777_0007_FFFF);
    check("R3 attr 512K", lk_attr, 8'h22);
    look(64'h0000_0100_0004_0000, 8'd5);
    check("R3 outside 64K page miss", lk_hit, 0);

    // R4/R10/R8: 4 MB in large-page array, locked 8K overlap in FA
    fill(64'h0000_0300_0040_0000, 8'd5, 44'h0AA_0040_0000, 2'b11, 0, 8'h33);
    look(64'h0000_0300_007F_1234, 8'd5);
    check("R10 hit 4M", lk_hit, 1);
    check("R10 pa 4M", lk_pa, 44'h0AA_007F_1234);
    check("R10 size 4M", lk_size, 2'b11);
    fill(64'h0000_0300_0050_0000, 8'd5, 44'h0BB_0000_0000, 2'b00, 1, 8'h44);
    look(64'h0000_0300_0050_0010, 8'd5);
    check("R8 multi flag", lk_multi, 1);
    check("R8 FA priority size", lk_size, 2'b00);
    check("R8 FA priority pa", lk_pa, 44'h0BB_0000_0010);
    check("R4 locked fill goes to FA attr", lk_attr, 8'h44);
    look(64'h0000_0300_0060_0010, 8'd5);
    check("R8 no multi elsewhere", lk_multi, 0);

    // R4: mode high places unlocked 4M into FA -> no cross-structure multi
    do_reset();
    mode_4m_fa = 1;
    fill(64'h0000_0300_0040_0000, 8'd5, 44'h0AA_0040_0000, 2'b11, 0, 8'h33);
    fill(64'h0000_0300_0050_0000, 8'd5, 44'h0BB_0000_0000, 2'b00, 1, 8'h44);
    look(64'h0000_0300_0050_0010, 8'd5);
    check("R4 mode1 hit", lk_hit, 1);
    check("R4 mode1 single structure", lk_multi, 0);
    look(64'h0000_0300_0070_0000, 8'd5);
    check("R4 mode1 4M pa", lk_pa, 44'h0AA_0070_0000);

    // R9: invalidate-all keeps locked entries
    fill(64'h0000_0400_0000_2000, 8'd5, 44'h010_0000_2000, 2'b00, 0, 8'h01);
    fill(64'h0000_0500_0001_0000, 8'd5, 44'h020_0001_0000, 2'b01, 1, 8'h02);
    pulse_inv();
    look(64'h0000_0400_0000_2000, 8'd5);
    check("R9 unlocked gone", lk_hit, 0);
    look(64'h0000_0300_0070_0000, 8'd5);
    check("R9 unlocked 4M gone", lk_hit, 0);
    look(64'h0000_0500_0001_0004, 8'd5);
    check("R9 locked kept", lk_hit, 1);

    // R6: set conflict in 8K array (8 sets -> 64 KB stride)
    do_reset();
    for (int k = 0; k < 4; k++)
      fill(64'h0000_0600_0000_4000 + 64'(k) * 64'h1_0000, 8'd5,
           44'h100_0000_0000 + 44'(k) * 44'h2000, 2'b00, 0, 8'(k));
    look(64'h0000_0600_0000_4000, 8'd5);
    check("R6 first fill evicted", lk_hit, 0);
    look(64'h0000_0600_0001_4000, 8'd5);
    check("R6 second fill evicted", lk_hit, 0);
    look(64'h0000_0600_0002_4000, 8'd5);
    check("R6 third fill resident", lk_hit, 1);
    look(64'h0000_0600_0003_4008, 8'd5);
    check("R6 fourth fill pa", lk_pa, 44'h100_0000_6008);

    // R7: FA round robin skipping locked entries
    do_reset();
    for (int k = 0; k < 10; k++)
      fill({16'h0700, 16'(k), 32'h0}, 8'd5, 44'h200_0000_0000 + 44'(k) * 44'h1_0000,
           2'b01, (k < 2), 8'(k));
    for (int k = 0; k < 10; k++) begin
      look({16'h0700, 16'(k), 32'h0}, 8'd5);
      check($sformatf("R7 entry %0d residency", k), lk_hit, (k == 2 || k == 3) ? 0 : 1);
    end

    // R11: overflow with all entries locked
    do_reset();
    for (int k = 0; k < 8; k++)
      fill({16'h0800, 16'(k), 32'h0}, 8'd5, 44'h300_0000_0000, 2'b01, 1, 8'(k));
    check("R11 no ovf while space", fill_ovf, 0);
    fill({16'h0800, 16'd9, 32'h0}, 8'd5, 44'h300_0000_0000, 2'b10, 1, 8'h9);
    check("R11 ovf raised", fill_ovf, 1);
    look({16'h0800, 16'd9, 32'h0}, 8'd5);
    check("R11 dropped fill misses", lk_hit, 0);
    look({16'h0800, 16'd0, 32'h0}, 8'd5);
    check("R11 locked entry kept", lk_hit, 1);
    fill({16'h0800, 16'd10, 32'h0}, 8'd5, 44'h300_0000_0000, 2'b00, 0, 8'h9);
    check("R11 ovf low for 8K array fill", fill_ovf, 0);

    // random mixed pages
    do_reset();
    for (int k = 0; k < 14; k++) begin
      va = {16'(k + 1), $urandom(), 16'($urandom())};
      if (k < 8) begin
        rv_sz[k] = 2'b00; va[15:13] = 3'(k);
      end else if (k < 12) begin
        rv_sz[k] = ($urandom() % 2) ? 2'b01 : 2'b10;
      end else begin
        rv_sz[k] = 2'b11; va[24:22] = 3'(k - 12);
      end
      rv_va[k] = va;
      rv_pa[k] = {12'($urandom()), $urandom()};
      fill(va, 8'd3, rv_pa[k], rv_sz[k], 0, 8'(k));
    end
    for (int t = 0; t < 60; t++) begin
      int e;
      e = $urandom() % 14;
      m = ~(64'hFFFF_FFFF_FFFF_FFFF << shift_of(rv_sz[e]));
      va = (rv_va[e] & ~m) | ({$urandom(), $urandom()} & m);
      look(va, 8'd3);
      if (rv_sz[e] == 2'b00)      check("R2 random hit", lk_hit, 1);
      else if (rv_sz[e] == 2'b11) check("R10 random hit", lk_hit, 1);
      else                        check("R3 random hit", lk_hit, 1);
      check("R3 random pa", lk_pa, exp_pa(rv_pa[e], rv_sz[e], va));
      check("R4 random size", lk_size, rv_sz[e]);
    end
    for (int t = 0; t < 20; t++) begin
      look({16'hFFFF, $urandom(), 16'($urandom())}, 8'd3);
      check("R5 random miss", lk_hit, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule